// File: doc/BRIEF.md
# Programmable Event Counter Bank

This block holds a set of performance counters for a processor core. Some are general counters, each steered by its own select register. The others are fixed-function counters that share one packed control register. Every cycle, the logic that watches the core supplies one small increment value per counter. A counter adds that value only if three things hold: its local enable is on, the current privilege mode is one it is allowed to count in, and its bit in the global control register is set.

When a counter wraps past its all-ones value, it sets a sticky bit in the global status register. Software acknowledges that bit by writing a mask to a separate clear register. The interrupt output is a level. It stays high while any status bit whose counter has its interrupt enable set remains pending.

A general counter can also carry a threshold. With a threshold set, the counter adds one on each cycle where the increment is at least the threshold, instead of adding the increment itself. All registers sit on a simple write-strobe bus with a combinational read port, and 64-bit data.

Top module: `evcnt_bank`

## Requirements
- R1: After a synchronous reset, every counter, select register, the fixed control register, global control and global status read zero, and the interrupt output is low.
- R2: A counter adds its per-cycle increment only when its local enable, its privilege-mode filter and its global control bit are all set. General counter i uses global bit i. Fixed counter j uses global bit 32+j, and the same position in the status register.
- R3: A general select register stores the low 32 bits written to it. Bits [15:0] hold an event code that is only stored. Bit 16 allows counting in user mode, bit 17 allows counting in supervisor mode, bit 20 enables the overflow interrupt, bit 22 is the local enable, and bits [31:24] are the threshold. Input priv_user=1 selects user mode and priv_user=0 selects supervisor mode.
- R4: Fixed counter j is controlled by the 4-bit field at bits [4j+3:4j] of the fixed control register. Field bit 0 allows supervisor counting, bit 1 allows user counting, bit 3 enables the overflow interrupt, and bit 2 is only stored. Counting needs one of the two mode bits to match the current mode. Fixed counters have no threshold.
- R5: With a non-zero threshold, a general counter adds exactly one on a cycle whose increment is greater than or equal to the threshold, and zero on any other cycle.
- R6: A carry out of the top counter bit sets the counter's status bit. A counter preloaded with the two's complement of N-1 reads 1 after N unit events.
- R7: Writing a mask to the clear register clears the status bits set in that mask and leaves the others unchanged. An overflow in the same cycle as a clear wins. The clear register reads zero.
- R8: The interrupt output is high exactly while some status bit is set whose counter has its interrupt enable set. An overflow on a counter without interrupt enable sets the status bit only.
- R9: A counter register can be written at any time. A write takes priority over an increment in the same cycle and does not set status.
- R10: Global control and status bits with no counter behind them read zero and cannot be set. Writes to the status address have no effect.
- R11: A counter that is not counting holds its value, and that value can be read back.
- R12: Register addresses are: general counter i at 0x00+i, general select i at 0x10+i, fixed counter j at 0x20+j, fixed control at 0x28, global control at 0x30, status at 0x31 and clear at 0x32. Counter values are zero-extended on read, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| priv_user | input | 1 | Current mode: 1 user, 0 supervisor |
| gp_evt_inc | input | NUM_GP*INC_W | Per-cycle increments, one lane per general counter |
| fx_evt_inc | input | NUM_FX*INC_W | Per-cycle increments, one lane per fixed counter |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Combinational read data for bus_addr |
| irq | output | 1 | Overflow interrupt level |

## Verification
The bound properties watch general counter 0 and assume the bus never writes two registers in one cycle. They also assume increments are sampled only on the clock edge. For the clear property, they take it that counter 0 cannot wrap while its global bit is off. The stimulus writes at most one register per cycle and changes inputs only at the falling edge. It preloads counters close to their wrap point, so overflow, clear and interrupt events occur often while global bits switch at random.

// File: rtl/evcnt_pkg.sv
// Shared constants and helpers for the event counter bank.
// Assumes a 64-bit register bus with an 8-bit address.
package evcnt_pkg;
    localparam int DATA_W  = 64;
    localparam int ADDR_W  = 8;
    localparam int FX_BASE = 32;
    localparam int THR_W   = 8;

    localparam logic [ADDR_W-1:0] A_GP_CNT  = 8'h00;
    localparam logic [ADDR_W-1:0] A_GP_SEL  = 8'h10;
    localparam logic [ADDR_W-1:0] A_FX_CNT  = 8'h20;
    localparam logic [ADDR_W-1:0] A_FX_CTL  = 8'h28;
    localparam logic [ADDR_W-1:0] A_GLB_CTL = 8'h30;
    localparam logic [ADDR_W-1:0] A_GLB_STS = 8'h31;
    localparam logic [ADDR_W-1:0] A_OVF_CLR = 8'h32;

    localparam int SEL_USR = 16;
    localparam int SEL_OS  = 17;
    localparam int SEL_INT = 20;
    localparam int SEL_EN  = 22;
    localparam int SEL_THR = 24;

    localparam int FX_OS  = 0;
    localparam int FX_USR = 1;
    localparam int FX_INT = 3;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic             en;
        logic             ie;
        logic             os;
        logic             usr;
    } sel_t;

    // Pull the control fields out of a general select register.
    function automatic sel_t decode_sel(input logic [31:0] r);
        sel_t s;
        s.thr = r[SEL_THR +: THR_W];
        s.en  = r[SEL_EN];
        s.ie  = r[SEL_INT];
        s.os  = r[SEL_OS];
        s.usr = r[SEL_USR];
        return s;
    endfunction

    // True when the current privilege mode is one the counter may count in.
    function automatic logic mode_ok(input logic user, input logic os_en,
                                     input logic usr_en);
        return user ? usr_en : os_en;
    endfunction
endpackage

// File: rtl/evcnt_slot.sv
// One counter register with its threshold filter and wrap detection.
// The run input already combines local enable, mode filter and global bit.
// A load from the bus overrides counting and never reports a wrap.
// A zero threshold makes the counter add the raw increment.
module evcnt_slot #(
    parameter int CNT_W = 40,
    parameter int INC_W = 4,
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [THR_W-1:0] thr,
    input  logic [INC_W-1:0] inc,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);
    localparam int CMP_W = (INC_W > THR_W) ? INC_W : THR_W;

    logic [CMP_W-1:0] inc_x;
    logic [CMP_W-1:0] thr_x;
    logic [INC_W-1:0] amt;
    logic [CNT_W:0]   sum;

    // Choose the step size and form the widened sum with its carry.
    always_comb begin
        inc_x = CMP_W'(inc);
        thr_x = CMP_W'(thr);
        if (thr == '0) begin
            amt = inc;
        end else if (inc_x >= thr_x) begin
            amt = INC_W'(1);
        end else begin
            amt = '0;
        end
        sum  = {1'b0, cnt_q} + (CNT_W+1)'(amt);
        wrap = run & ~ld & sum[CNT_W];
    end

    // Counter register: a bus load first, then counting when running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld) begin
            cnt_q <= ld_val;
        end else if (run) begin
            cnt_q <= sum[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/evcnt_status.sv
// Sticky overflow status and the level interrupt built from it.
// Bits outside IMPL never set. A new overflow beats a clear in the same cycle.
module evcnt_status #(
    parameter int           W    = 64,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] ie_vec,
    output logic [W-1:0] sts_q,
    output logic         irq
);
    logic [W-1:0] clr_eff;

    // Clear mask applies only on a write to the clear register.
    always_comb begin
        clr_eff = clr_we ? clr_mask : '0;
    end

    // Status register update: drop acknowledged bits, then add new overflows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= ((sts_q & ~clr_eff) | set_vec) & IMPL;
        end
    end

    // Interrupt level: any pending status bit whose counter asks for one.
    assign irq = |(sts_q & ie_vec);
endmodule

// File: rtl/evcnt_bank.sv
// Bank of general and fixed event counters behind a simple register bus.
// Assumes NUM_GP <= 16, NUM_FX <= 8 and CNT_W <= 64, so the address windows and
// the data bus hold everything. Reads are combinational; writes take effect
// at the clock edge.
module evcnt_bank
    import evcnt_pkg::*;
#(
    parameter int NUM_GP = 4,
    parameter int NUM_FX = 3,
    parameter int CNT_W  = 40,
    parameter int INC_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     priv_user,
    input  logic [NUM_GP*INC_W-1:0]  gp_evt_inc,
    input  logic [NUM_FX*INC_W-1:0]  fx_evt_inc,
    input  logic                     bus_we,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     irq
);
    localparam int FX_CTL_W = 4 * NUM_FX;
    localparam logic [DATA_W-1:0] GP_MASK   = (64'd1 << NUM_GP) - 64'd1;
    localparam logic [DATA_W-1:0] FX_MASK   = ((64'd1 << NUM_FX) - 64'd1) << FX_BASE;
    localparam logic [DATA_W-1:0] IMPL_MASK = GP_MASK | FX_MASK;

    logic [31:0]         gp_sel_q [NUM_GP];
    logic [FX_CTL_W-1:0] fx_ctl_q;
    logic [DATA_W-1:0]   glb_ctl_q;
    logic [CNT_W-1:0]    gp_cnt [NUM_GP];
    logic [CNT_W-1:0]    fx_cnt [NUM_FX];
    logic [NUM_GP-1:0]   gp_wrap;
    logic [NUM_GP-1:0]   gp_ie;
    logic [NUM_FX-1:0]   fx_wrap;
    logic [NUM_FX-1:0]   fx_ie;
    logic [DATA_W-1:0]   set_vec;
    logic [DATA_W-1:0]   ie_vec;
    logic [DATA_W-1:0]   ovf_sts;

    logic [NUM_GP-1:0]   gp_cnt_we;
    logic [NUM_GP-1:0]   gp_sel_we;
    logic [NUM_FX-1:0]   fx_cnt_we;
    logic                fx_ctl_we;
    logic                glb_we;
    logic                clr_we;

    // Address decode into one write strobe per register.
    always_comb begin
        for (int i = 0; i < NUM_GP; i++) begin
            gp_cnt_we[i] = bus_we && (bus_addr == A_GP_CNT + ADDR_W'(i));
            gp_sel_we[i] = bus_we && (bus_addr == A_GP_SEL + ADDR_W'(i));
        end
        for (int j = 0; j < NUM_FX; j++) begin
            fx_cnt_we[j] = bus_we && (bus_addr == A_FX_CNT + ADDR_W'(j));
        end
        fx_ctl_we = bus_we && (bus_addr == A_FX_CTL);
        glb_we    = bus_we && (bus_addr == A_GLB_CTL);
        clr_we    = bus_we && (bus_addr == A_OVF_CLR);
    end

    // Control registers: selects, packed fixed control and the global mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_GP; i++) begin
                gp_sel_q[i] <= '0;
            end
            fx_ctl_q  <= '0;
            glb_ctl_q <= '0;
        end else begin
            for (int i = 0; i < NUM_GP; i++) begin
                if (gp_sel_we[i]) begin
                    gp_sel_q[i] <= bus_wdata[31:0];
                end
            end
            if (fx_ctl_we) begin
                fx_ctl_q <= bus_wdata[FX_CTL_W-1:0];
            end
            if (glb_we) begin
                glb_ctl_q <= bus_wdata & IMPL_MASK;
            end
        end
    end

    // General counters, each gated by its select fields and global bit.
    for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
        sel_t fld;
        logic run;
        assign fld = decode_sel(gp_sel_q[g]);
        assign run = fld.en & glb_ctl_q[g] & mode_ok(priv_user, fld.os, fld.usr);
        assign gp_ie[g] = fld.ie;

        evcnt_slot #(
            .CNT_W (CNT_W),
            .INC_W (INC_W),
            .THR_W (THR_W)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run),
            .thr    (fld.thr),
            .inc    (gp_evt_inc[g*INC_W +: INC_W]),
            .ld     (gp_cnt_we[g]),
            .ld_val (bus_wdata[CNT_W-1:0]),
            .cnt_q  (gp_cnt[g]),
            .wrap   (gp_wrap[g])
        );
    end

    // Fixed counters, each gated by its 4-bit field and a high global bit.
    for (genvar g = 0; g < NUM_FX; g++) begin : g_fx
        logic [3:0] fld;
        logic       run;
        assign fld = fx_ctl_q[4*g +: 4];
        assign run = glb_ctl_q[FX_BASE + g] & mode_ok(priv_user, fld[FX_OS], fld[FX_USR]);
        assign fx_ie[g] = fld[FX_INT];

        evcnt_slot #(
            .CNT_W (CNT_W),
            .INC_W (INC_W),
            .THR_W (THR_W)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run),
            .thr    ({THR_W{1'b0}}),
            .inc    (fx_evt_inc[g*INC_W +: INC_W]),
            .ld     (fx_cnt_we[g]),
            .ld_val (bus_wdata[CNT_W-1:0]),
            .cnt_q  (fx_cnt[g]),
            .wrap   (fx_wrap[g])
        );
    end

    // Place wrap and interrupt-enable bits at their global positions.
    always_comb begin
        set_vec = '0;
        ie_vec  = '0;
        set_vec[NUM_GP-1:0]       = gp_wrap;
        ie_vec[NUM_GP-1:0]        = gp_ie;
        set_vec[FX_BASE +: NUM_FX] = fx_wrap;
        ie_vec[FX_BASE +: NUM_FX]  = fx_ie;
    end

    evcnt_status #(
        .W    (DATA_W),
        .IMPL (IMPL_MASK)
    ) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_we   (clr_we),
        .clr_mask (bus_wdata),
        .ie_vec   (ie_vec),
        .sts_q    (ovf_sts),
        .irq      (irq)
    );

    // Read mux: unmapped and write-only addresses return zero.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_GP; i++) begin
            if (bus_addr == A_GP_CNT + ADDR_W'(i)) bus_rdata = DATA_W'(gp_cnt[i]);
            if (bus_addr == A_GP_SEL + ADDR_W'(i)) bus_rdata = DATA_W'(gp_sel_q[i]);
        end
        for (int j = 0; j < NUM_FX; j++) begin
            if (bus_addr == A_FX_CNT + ADDR_W'(j)) bus_rdata = DATA_W'(fx_cnt[j]);
        end
        if (bus_addr == A_FX_CTL)  bus_rdata = DATA_W'(fx_ctl_q);
        if (bus_addr == A_GLB_CTL) bus_rdata = glb_ctl_q;
        if (bus_addr == A_GLB_STS) bus_rdata = ovf_sts;
    end
endmodule

// File: rtl/evcnt_bank_chk.sv
// Property checker for the counter bank, bound to its top module.
// Watches general counter 0, the status register and the interrupt level.
module evcnt_bank_chk
    import evcnt_pkg::*;
#(
    parameter int                CNT_W = 40,
    parameter int                INC_W = 4,
    parameter logic [DATA_W-1:0] IMPL  = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              priv_user,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input logic [DATA_W-1:0] sts,
    input logic [DATA_W-1:0] glb,
    input logic [31:0]       sel0,
    input logic [CNT_W-1:0]  cnt0,
    input logic [INC_W-1:0]  inc0
);
    logic wr_cnt0;
    logic wr_clr;
    logic run0;

    // Observed bus events and counter 0 activity.
    always_comb begin
        wr_cnt0 = bus_we && (bus_addr == A_GP_CNT);
        wr_clr  = bus_we && (bus_addr == A_OVF_CLR);
        run0    = sel0[SEL_EN] && glb[0] && (priv_user ? sel0[SEL_USR] : sel0[SEL_OS]);
    end

    // R7
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && bus_wdata[0] && !glb[0]) |=> !sts[0]);

    // R7
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[0] && !(wr_clr && bus_wdata[0])) |=> sts[0]);

    // R11
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb[0] && !wr_cnt0) |=> $stable(cnt0));

    // R10
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & ~IMPL) == '0) && ((glb & ~IMPL) == '0));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts == '0) |-> !irq);

    // R5
    thr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run0 && sel0[SEL_THR +: THR_W] != '0 && !wr_cnt0)
        |=> (cnt0 == $past(cnt0) || cnt0 == $past(cnt0) + CNT_W'(1)));

    // R9
    write_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt0 |=> (cnt0 == $past(bus_wdata[CNT_W-1:0])));

    // R2
    idle_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run0 && inc0 == '0 && !wr_cnt0) |=> $stable(cnt0));
endmodule

bind evcnt_bank evcnt_bank_chk #(
    .CNT_W (CNT_W),
    .INC_W (INC_W),
    .IMPL  (IMPL_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .priv_user (priv_user),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .sts       (ovf_sts),
    .glb       (glb_ctl_q),
    .sel0      (gp_sel_q[0]),
    .cnt0      (gp_cnt[0]),
    .inc0      (gp_evt_inc[INC_W-1:0])
);

// File: tb/evcnt_bank_bench.sv
module evcnt_bank_bench;
    localparam int CLK_P = 10;
    localparam int NG = 4;
    localparam int NF = 3;
    localparam int NC = NG + NF;
    localparam int CW = 40;
    localparam int IW = 4;
    localparam logic [63:0] IMPL = 64'h0000_0007_0000_000F;
    localparam logic [63:0] B_USR = 64'h1 << 16;
    localparam logic [63:0] B_OS  = 64'h1 << 17;
    localparam logic [63:0] B_INT = 64'h1 << 20;
    localparam logic [63:0] B_EN  = 64'h1 << 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          priv_user = 1'b0;
    logic [NG*IW-1:0] gp_inc = '0;
    logic [NF*IW-1:0] fx_inc = '0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [63:0]   bus_wdata = '0;
    logic [63:0]   bus_rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [CW-1:0] m_cnt [NC];
    logic [31:0]   m_sel [NG];
    logic [11:0]   m_fxc = '0;
    logic [63:0]   m_glb = '0;
    logic [63:0]   m_sts = '0;

    always #(CLK_P/2) clk = ~clk;

    evcnt_bank #(.NUM_GP(NG), .NUM_FX(NF), .CNT_W(CW), .INC_W(IW)) u_evcnt_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .priv_user  (priv_user),
        .gp_evt_inc (gp_inc),
        .fx_evt_inc (fx_inc),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq        (irq)
    );

    function automatic int gbit(int k);
        return (k < NG) ? k : 32 + k - NG;
    endfunction

    function automatic logic [7:0] cnt_addr(int k);
        return (k < NG) ? 8'(k) : 8'(8'h20 + k - NG);
    endfunction

    // Expected register read value from the model (R12 map).
    function automatic logic [63:0] exp_read(logic [7:0] a);
        logic [63:0] v = '0;
        for (int k = 0; k < NC; k++) if (a == cnt_addr(k)) v = 64'(m_cnt[k]);
        for (int i = 0; i < NG; i++) if (a == 8'(8'h10 + i)) v = 64'(m_sel[i]);
        if (a == 8'h28) v = 64'(m_fxc);
        if (a == 8'h30) v = m_glb;
        if (a == 8'h31) v = m_sts;
        return v;
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int i = 0; i < NG; i++) if (m_sts[i] && m_sel[i][20]) r = 1'b1;
        for (int j = 0; j < NF; j++) if (m_sts[32+j] && m_fxc[4*j+3]) r = 1'b1;
        return r;
    endfunction

    // Advance the model by one clock using the inputs now driven.
    function automatic void model_step();
        logic [63:0] setv = '0;
        logic [63:0] clr = '0;
        for (int k = 0; k < NC; k++) begin
            logic [IW-1:0] inc;
            logic run;
            logic [7:0] thr;
            logic [IW-1:0] amt;
            logic [CW:0] sum;
            if (k < NG) begin
                inc = gp_inc[k*IW +: IW];
                thr = m_sel[k][31:24];
                run = m_sel[k][22] && m_glb[k] && (priv_user ? m_sel[k][16] : m_sel[k][17]);
            end else begin
                inc = fx_inc[(k-NG)*IW +: IW];
                thr = '0;
                run = m_glb[gbit(k)] && (priv_user ? m_fxc[4*(k-NG)+1] : m_fxc[4*(k-NG)]);
            end
            if (thr == 0) amt = inc;
            else amt = (8'(inc) >= thr) ? IW'(1) : '0;
            if (bus_we && bus_addr == cnt_addr(k)) begin
                m_cnt[k] = bus_wdata[CW-1:0];
            end else if (run) begin
                sum = {1'b0, m_cnt[k]} + (CW+1)'(amt);
                if (sum[CW]) setv[gbit(k)] = 1'b1;
                m_cnt[k] = sum[CW-1:0];
            end
        end
        if (bus_we) begin
            for (int i = 0; i < NG; i++) if (bus_addr == 8'(8'h10 + i)) m_sel[i] = bus_wdata[31:0];
            if (bus_addr == 8'h28) m_fxc = bus_wdata[11:0];
            if (bus_addr == 8'h30) m_glb = bus_wdata & IMPL;
            if (bus_addr == 8'h32) clr = bus_wdata;
        end
        m_sts = ((m_sts & ~clr) | setv) & IMPL;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock; afterwards compare the read port and the interrupt level.
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("R8 irq level", 64'(irq), 64'(exp_irq()));
        chk("R2 R12 readback", bus_rdata, exp_read(bus_addr));
    endtask

    task automatic wr(logic [7:0] a, logic [63:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        cycle();
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [63:0] exp);
        bus_we = 1'b0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        chk({tag, " model"}, bus_rdata, exp_read(a));
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [4:0] vals [5];
        vals[0] = 1; vals[1] = 3; vals[2] = 2; vals[3] = 0; vals[4] = 4;
        for (int k = 0; k < NC; k++) m_cnt[k] = '0;
        for (int i = 0; i < NG; i++) m_sel[i] = '0;
        void'($urandom(32'd4242));

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int k = 0; k < NC; k++) rd_chk("R1 counter reset", cnt_addr(k), 64'h0);
        for (int i = 0; i < NG; i++) rd_chk("R1 select reset", 8'(8'h10 + i), 64'h0);
        rd_chk("R1 fixed ctl reset", 8'h28, 64'h0);
        rd_chk("R1 global reset", 8'h30, 64'h0);
        rd_chk("R1 status reset", 8'h31, 64'h0);
        chk("R1 irq reset", 64'(irq), 64'h0);

        // R6 R8: overflow without interrupt enable, N=5
        wr(8'h10, B_EN | B_OS | B_USR | 64'h3C);
        wr(8'h00, 64'h0000_00FF_FFFF_FFFC);
        wr(8'h30, 64'h1);
        gp_inc = 16'h0001;
        repeat (5) cycle();
        gp_inc = '0;
        wr(8'h30, 64'h0);
        rd_chk("R6 reads one after N", 8'h00, 64'h1);
        rd_chk("R6 status set", 8'h31, 64'h1);
        chk("R8 no irq without enable", 64'(irq), 64'h0);
        rd_chk("R3 event code stored", 8'h10, B_EN | B_OS | B_USR | 64'h3C);
        wr(8'h32, 64'h1);
        rd_chk("R7 status cleared", 8'h31, 64'h0);

        // R8 R7: overflow with interrupt enable, selective clear
        wr(8'h11, B_EN | B_OS | B_USR | B_INT);
        wr(8'h01, 64'h0000_00FF_FFFF_FFFF);
        wr(8'h30, 64'h2);
        gp_inc = 16'h0010;
        repeat (2) cycle();
        gp_inc = '0;
        wr(8'h30, 64'h0);
        rd_chk("R6 counter1 value", 8'h01, 64'h1);
        chk("R8 irq raised", 64'(irq), 64'h1);
        wr(8'h32, 64'h1);
        chk("R7 other mask keeps irq", 64'(irq), 64'h1);
        rd_chk("R7 other bit kept", 8'h31, 64'h2);
        wr(8'h32, 64'h2);
        chk("R8 irq dropped", 64'(irq), 64'h0);

        // R4 R2: fixed counter 0, supervisor + interrupt, N=3
        priv_user = 1'b0;
        wr(8'h28, 64'h9);
        wr(8'h20, 64'h0000_00FF_FFFF_FFFE);
        wr(8'h30, 64'h1_0000_0000);
        fx_inc = 12'h001;
        repeat (3) cycle();
        fx_inc = '0;
        rd_chk("R4 fixed value", 8'h20, 64'h1);
        rd_chk("R2 fixed status position", 8'h31, 64'h1_0000_0000);
        chk("R4 fixed irq", 64'(irq), 64'h1);
        wr(8'h32, 64'h1_0000_0000);
        chk("R7 fixed clear", 64'(irq), 64'h0);

        // R3 mode filter: supervisor-only counter in user mode
        wr(8'h12, B_EN | B_OS);
        wr(8'h30, 64'h4);
        priv_user = 1'b1;
        gp_inc = 16'h0300;
        repeat (4) cycle();
        rd_chk("R3 user mode filtered", 8'h02, 64'h0);
        priv_user = 1'b0;
        repeat (2) cycle();
        gp_inc = '0;
        rd_chk("R3 supervisor counts", 8'h02, 64'h6);

        // R5 threshold of 2 against an unthresholded counter
        wr(8'h13, B_EN | B_OS | B_USR | (64'h2 << 24));
        wr(8'h02, 64'h0);
        wr(8'h30, 64'hC);
        for (int t = 0; t < 5; t++) begin
            gp_inc = {vals[t][3:0], vals[t][3:0], 8'h00};
            cycle();
        end
        gp_inc = '0;
        rd_chk("R5 thresholded count", 8'h03, 64'h3);
        rd_chk("R5 raw count", 8'h02, 64'hA);

        // R9 write beats increment
        gp_inc = 16'h4000;
        wr(8'h03, 64'h55);
        gp_inc = '0;
        rd_chk("R9 write priority", 8'h03, 64'h55);

        // R11 hold after global then local disable
        wr(8'h30, 64'h0);
        wr(8'h13, 64'h0);
        gp_inc = 16'hFFFF;
        fx_inc = 12'hFFF;
        repeat (5) cycle();
        gp_inc = '0;
        fx_inc = '0;
        rd_chk("R11 hold counter3", 8'h03, 64'h55);
        rd_chk("R11 hold counter2", 8'h02, 64'hA);
        rd_chk("R11 hold fixed0", 8'h20, 64'h1);

        // R10 unimplemented bits, status not writable
        wr(8'h30, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk("R10 global mask", 8'h30, IMPL);
        wr(8'h31, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk("R10 status unwritable", 8'h31, 64'h0);
        rd_chk("R7 clear reads zero", 8'h32, 64'h0);
        rd_chk("R12 unmapped zero", 8'h40, 64'h0);
        wr(8'h30, 64'h0);

        // Random phase against the model
        for (int n = 0; n < 4000; n++) begin
            int sel;
            logic [63:0] d;
            priv_user = 1'($urandom);
            gp_inc = 16'($urandom);
            fx_inc = 12'($urandom);
            bus_we = ($urandom % 6) == 0;
            sel = $urandom % 16;
            d = {$urandom, $urandom};
            if (sel < 4) begin
                bus_addr = 8'(sel);
                if ($urandom % 4 != 0) d = {24'h0, 32'hFFFF_FFFF, 8'($urandom)};
            end else if (sel < 8) begin
                bus_addr = 8'(8'h10 + sel - 4);
                d[31:27] = '0;
                d[22] = ($urandom % 4) != 0;
            end else if (sel < 11) begin
                bus_addr = 8'(8'h20 + sel - 8);
                if ($urandom % 4 != 0) d = {24'h0, 32'hFFFF_FFFF, 8'($urandom)};
            end else if (sel == 11) bus_addr = 8'h28;
            else if (sel == 12) bus_addr = 8'h30;
            else if (sel == 13) bus_addr = 8'h32;
            else if (sel == 14) bus_addr = 8'h31;
            else bus_addr = 8'h40;
            bus_wdata = d;
            cycle();
        end
        bus_we = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule